// File: doc/BRIEF.md
# Binary64 Compare and Scale Unit

This unit applies one of four inexpensive operations to IEEE 754 binary64 words, chosen by a 2-bit opcode. It can pass the first operand through while comparing, flip its sign, halve it, or double it. A less-than flag comparing the two operands is produced on every cycle, whatever the opcode. The ordering test treats the raw words as signed integers and swaps the sense of the test when both operands carry a set sign bit. Halving and doubling move only the exponent field by one step, and they handle a zero exponent field so that zero stays zero.

Both outputs are registered, so a result appears one clock after its operands and opcode are presented. The caller must not supply infinities or NaNs. The caller must also avoid exponents that would step out of range: halving a value whose exponent field is one, or doubling a value whose exponent field is at its maximum, gives an unspecified result. The widths of the exponent and mantissa fields are parameters, so a narrow build can be checked exhaustively.

Top module: `fp64_cmp_scale`

## Requirements
- R1: While rst_n is low at a rising clock edge, result_o and lt_o are cleared to zero on that edge.
- R2: lt_o equals the signed two's-complement test a < b on the raw words whenever at least one operand has bit W-1 (the sign) clear. This holds for every opcode.
- R3: When both operands have the sign bit set, lt_o equals the signed test a > b on the raw words, so two equal negative words give 0.
- R4: Negative zero compares below positive zero (lt_o = 1), and positive zero does not compare below negative zero (lt_o = 0).
- R5: Opcode 2'b00 (compare) returns a unchanged on result_o.
- R6: Opcode 2'b01 (negate) returns a with only its top bit inverted.
- R7: Opcode 2'b10 (halve) with a nonzero exponent field (bits W-2 down to MAN_W) returns a with the exponent field lowered by one, and the sign and mantissa unchanged.
- R8: Opcode 2'b10 with a zero exponent field returns the all-zero word, whatever the sign and mantissa.
- R9: Opcode 2'b11 (double) with an exponent field that is neither zero nor at its maximum returns a with the exponent field raised by one, and the sign and mantissa unchanged.
- R10: Opcode 2'b11 with a zero exponent field returns a unchanged.
- R11: result_o and lt_o reflect the operands and opcode sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 2 | Operation select: 00 compare, 01 negate, 10 halve, 11 double |
| a_i | input | W (64) | First operand, the one that is transformed |
| b_i | input | W (64) | Second operand, used only for the compare |
| result_o | output | W (64) | Registered result word |
| lt_o | output | 1 | Registered flag, set when a < b |

## Verification
A narrow build with a 3-bit exponent and a 2-bit mantissa is swept over every pair of operands. The sweep covers every sign combination, so it separates the plain signed test from the reversed test used when both operands are negative. Equal pairs show that the reversal never reports a word as smaller than itself, and the two zero encodings confirm that negative zero sorts below positive zero. Every word of the narrow build is also negated, halved and doubled, which separates nonzero exponents from a zero exponent field of either sign. A few directed binary64 values, such as one, two, minus one and minus two, confirm the full-width build.

// File: rtl/fpcs_pkg.sv
// Package: fpcs_pkg
// Shared opcode encoding for the compare and scale unit.
// Assumes a 2-bit opcode field on the top-level interface.
package fpcs_pkg;

    typedef enum logic [1:0] {
        FPCS_CMP    = 2'b00,
        FPCS_NEGATE = 2'b01,
        FPCS_HALVE  = 2'b10,
        FPCS_DOUBLE = 2'b11
    } fpcs_op_e;

endpackage

// File: rtl/fpcs_order.sv
// Module: fpcs_order
// Purely combinational ordering of two floating-point words.
// The raw words are treated as signed integers. When both sign bits are set,
// the greater-than result is used in place of less-than, so equal words give 0.
// Assumes no NaN operands.
module fpcs_order #(
    parameter int W = 64
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic         lt_o
);

    logic signed [W-1:0] xs;
    logic signed [W-1:0] ys;
    logic                int_lt;
    logic                int_gt;
    logic                both_neg;

    assign xs = x_i;
    assign ys = y_i;

    // Form both signed comparisons and the both-negative selector.
    always_comb begin
        int_lt   = (xs < ys);
        int_gt   = (xs > ys);
        both_neg = x_i[W-1] & y_i[W-1];
        lt_o     = both_neg ? int_gt : int_lt;
    end

endmodule

// File: rtl/fpcs_exp_step.sv
// Module: fpcs_exp_step
// Moves the exponent field of one word by a single step, down or up,
// selected by the DOWN parameter.
// Down: subtract one exponent unit. A borrow that leaves the exponent field
// all ones (zero-exponent input) clears the whole word.
// Up: add one exponent unit only if the exponent field is nonzero.
// Assumes the caller keeps the exponent field inside its range.
module fpcs_exp_step #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    parameter bit DOWN  = 1'b1
) (
    input  logic [1+EXP_W+MAN_W-1:0] x_i,
    output logic [1+EXP_W+MAN_W-1:0] y_o
);

    localparam int W = 1 + EXP_W + MAN_W;
    localparam logic [W-1:0] EXP_ONE = {{(W-MAN_W-1){1'b0}}, 1'b1, {MAN_W{1'b0}}};

    generate
        if (DOWN) begin : g_down
            logic [W-1:0] diff;
            // Subtract one exponent unit and clear the word on an all-ones exponent.
            always_comb begin
                diff = x_i - EXP_ONE;
                if (&diff[W-2:MAN_W]) begin
                    y_o = '0;
                end else begin
                    y_o = diff;
                end
            end
        end else begin : g_up
            // Add one exponent unit unless the exponent field is zero.
            always_comb begin
                if (|x_i[W-2:MAN_W]) begin
                    y_o = x_i + EXP_ONE;
                end else begin
                    y_o = x_i;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fp64_cmp_scale.sv
// Module: fp64_cmp_scale
// Top of the compare and scale unit. It selects pass-through, negate, halve
// or double for operand a, and it always compares a against b. Both outputs
// are registered, giving one cycle of latency, and use a synchronous
// active-low reset. Assumes no infinities, NaNs or out-of-range exponents.
module fp64_cmp_scale #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               op_i,
    input  logic [1+EXP_W+MAN_W-1:0] a_i,
    input  logic [1+EXP_W+MAN_W-1:0] b_i,
    output logic [1+EXP_W+MAN_W-1:0] result_o,
    output logic                     lt_o
);

    import fpcs_pkg::*;

    localparam int W = 1 + EXP_W + MAN_W;

    fpcs_op_e     op_sel;
    logic [W-1:0] half_w;
    logic [W-1:0] dbl_w;
    logic [W-1:0] next_res;
    logic         next_lt;

    assign op_sel = fpcs_op_e'(op_i);

    fpcs_order #(.W(W)) u_order (
        .x_i  (a_i),
        .y_i  (b_i),
        .lt_o (next_lt)
    );

    fpcs_exp_step #(.EXP_W(EXP_W), .MAN_W(MAN_W), .DOWN(1'b1)) u_halve (
        .x_i (a_i),
        .y_o (half_w)
    );

    fpcs_exp_step #(.EXP_W(EXP_W), .MAN_W(MAN_W), .DOWN(1'b0)) u_double (
        .x_i (a_i),
        .y_o (dbl_w)
    );

    // Pick the result word for the current opcode.
    always_comb begin
        case (op_sel)
            FPCS_CMP:    next_res = a_i;
            FPCS_NEGATE: next_res = {~a_i[W-1], a_i[W-2:0]};
            FPCS_HALVE:  next_res = half_w;
            FPCS_DOUBLE: next_res = dbl_w;
            default:     next_res = a_i;
        endcase
    end

    // Register both outputs, clearing them on a synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            lt_o     <= 1'b0;
        end else begin
            result_o <= next_res;
            lt_o     <= next_lt;
        end
    end

endmodule

// File: rtl/fp64_cmp_scale_chk.sv
// Module: fp64_cmp_scale_chk
// Assertion checker attached to fp64_cmp_scale by the bind below.
// Relates the registered outputs to the inputs of the previous cycle.
module fp64_cmp_scale_chk #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               op_i,
    input logic [1+EXP_W+MAN_W-1:0] a_i,
    input logic [1+EXP_W+MAN_W-1:0] b_i,
    input logic [1+EXP_W+MAN_W-1:0] result_o,
    input logic                     lt_o
);

    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] a_exp;
    logic             a_sign;
    logic [W-2:0]     a_rest;
    logic             a_neg_zero;
    logic             b_pos_zero;

    assign a_exp      = a_i[W-2:MAN_W];
    assign a_sign     = a_i[W-1];
    assign a_rest     = a_i[W-2:0];
    assign a_neg_zero = (a_i == {1'b1, {(W-1){1'b0}}});
    assign b_pos_zero = (b_i == '0);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (result_o == '0 && !lt_o));

    // R3
    eq_not_less_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(a_i == b_i)) |-> !lt_o);

    // R4
    neg_zero_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(a_neg_zero && b_pos_zero)) |-> lt_o);

    // R6
    negate_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'b01) |->
            (result_o[W-1] == !$past(a_sign) && result_o[W-2:0] == $past(a_rest)));

    // R8
    halve_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'b10 && $past(a_exp) == '0) |-> result_o == '0);

    // R10
    double_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'b11 && $past(a_exp) == '0) |-> result_o == $past(a_i));

endmodule

bind fp64_cmp_scale fp64_cmp_scale_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .lt_o     (lt_o)
);

// File: tb/fp64_cmp_scale_tb.sv
// Bench: exhaustive sweep of a 6-bit build (3-bit exponent, 2-bit mantissa),
// plus directed full-width binary64 values.
module fp64_cmp_scale_tb;

    localparam int SE = 3;
    localparam int SM = 2;
    localparam int SW = 1 + SE + SM;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [SW-1:0] a = '0;
    logic [SW-1:0] b = '0;
    logic [SW-1:0] res;
    logic          lt;

    logic [1:0]    fop = 2'b00;
    logic [63:0]   fa = '0;
    logic [63:0]   fb = '0;
    logic [63:0]   fres;
    logic          flt;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fp64_cmp_scale #(.EXP_W(SE), .MAN_W(SM)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
        .result_o(res), .lt_o(lt)
    );

    fp64_cmp_scale u_dut_full (
        .clk(clk), .rst_n(rst_n), .op_i(fop), .a_i(fa), .b_i(fb),
        .result_o(fres), .lt_o(flt)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Ordering key of a small word: the magnitude, mapped below zero when negative.
    function automatic int key(input logic [SW-1:0] x);
        int mag;
        mag = int'(x[SW-2:0]);
        return x[SW-1] ? (-mag - 1) : mag;
    endfunction

    task automatic step(input logic [1:0] o, input logic [SW-1:0] x, input logic [SW-1:0] y,
                        input logic [1:0] fo, input logic [63:0] fx, input logic [63:0] fy);
        @(negedge clk);
        op = o; a = x; b = y; fop = fo; fa = fx; fb = fy;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        a = 6'h15; b = 6'h02; op = 2'b11;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs cleared while in reset
        check("R1 result", 64'(res), 64'h0);
        check("R1 lt", 64'(lt), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R11: every pair in compare mode
        for (int i = 0; i < (1 << SW); i++) begin
            for (int j = 0; j < (1 << SW); j++) begin
                logic [SW-1:0] x;
                logic [SW-1:0] y;
                logic          e_lt;
                x = SW'(i); y = SW'(j);
                e_lt = key(x) < key(y);
                step(2'b00, x, y, 2'b00, 64'h0, 64'h0);
                if (x == {1'b1, {(SW-1){1'b0}}} && y == '0)
                    check("R4 -0<+0", 64'(lt), 64'h1);
                else if (x == '0 && y == {1'b1, {(SW-1){1'b0}}})
                    check("R4 +0<-0", 64'(lt), 64'h0);
                else if (x[SW-1] && y[SW-1])
                    check("R3 both negative", 64'(lt), 64'(e_lt));
                else
                    check("R2 signed compare", 64'(lt), 64'(e_lt));
                check("R5 R11 pass-through", 64'(res), 64'(x));
            end
        end

        // R6 R7 R8 R9 R10: every word negated, halved, doubled
        for (int i = 0; i < (1 << SW); i++) begin
            logic [SW-1:0] x;
            logic [SE-1:0] ex;
            x = SW'(i);
            ex = x[SW-2:SM];
            step(2'b01, x, 6'h07, 2'b00, 64'h0, 64'h0);
            check("R6 negate", 64'(res), 64'(x ^ {1'b1, {(SW-1){1'b0}}}));
            check("R2 flag in other op", 64'(lt), 64'(key(x) < key(6'h07)));
            step(2'b10, x, 6'h00, 2'b00, 64'h0, 64'h0);
            if (ex == 0)
                check("R8 halve zero exp", 64'(res), 64'h0);
            else
                check("R7 halve", 64'(res), 64'({x[SW-1], SE'(ex - 1), x[SM-1:0]}));
            if (ex != {SE{1'b1}}) begin
                step(2'b11, x, 6'h00, 2'b00, 64'h0, 64'h0);
                if (ex == 0)
                    check("R10 double zero exp", 64'(res), 64'(x));
                else
                    check("R9 double", 64'(res), 64'({x[SW-1], SE'(ex + 1), x[SM-1:0]}));
            end
        end

        // Full width: halve 1.0, double 1.0, compare -2 against -1, halve -0
        step(2'b00, 6'h0, 6'h0, 2'b10, 64'h3FF0_0000_0000_0000, 64'h0);
        check("R7 full halve 1.0", fres, 64'h3FE0_0000_0000_0000);
        step(2'b00, 6'h0, 6'h0, 2'b11, 64'h3FF0_0000_0000_0000, 64'h0);
        check("R9 full double 1.0", fres, 64'h4000_0000_0000_0000);
        step(2'b00, 6'h0, 6'h0, 2'b00, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000);
        check("R3 full -2<-1", 64'(flt), 64'h1);
        step(2'b00, 6'h0, 6'h0, 2'b00, 64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000);
        check("R3 full -1<-2", 64'(flt), 64'h0);
        step(2'b00, 6'h0, 6'h0, 2'b10, 64'h8000_0000_0000_0000, 64'h0);
        check("R8 full halve -0", fres, 64'h0);
        step(2'b00, 6'h0, 6'h0, 2'b01, 64'h3FF0_0000_0000_0000, 64'h0);
        check("R6 full negate", fres, 64'hBFF0_0000_0000_0000);

        // R1: reset asserted mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0; op = 2'b01; a = 6'h15;
        @(posedge clk);
        #1;
        check("R1 reset mid-run", 64'(res), 64'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule